// File: doc/BRIEF.md
# Banked Character Capture Register

This block holds the character most recently read from each of several storage modules. There is one character-wide register per module. Each register only gathers 1 bits: a bit that a sense input sets stays set until a clear pulse for that module removes it. The next read then starts from an empty register.

Two gates drive the contents of the selected register outward, and each has its own enable:
- the data readout path;
- the inhibit path used for rewrite.

When neither enable is active, or the select names no register, the corresponding output is all zeros.

A clear must come before every read. A cycle-start strobe therefore checks the selected register. If any bit survived the clear, old bits would merge into the incoming character, so the block raises an error flag. The flag stays set until the global reset.

Top module: `bank_capture_reg`

## Requirements
- R1: After the synchronous reset `rst`, every register is zero, `rd_data` and `inh_data` are zero and `read_err` is 0.
- R2: On a clock edge, without `clr`, the register named by `bank_sel` (value k selects register k) takes the bitwise OR of its contents and `sense`. All other registers keep their contents.
- R3: On a clock edge with `clr` high, the selected register becomes zero, even if `sense` is non-zero in the same cycle. Other registers keep their contents.
- R4: At each edge, `rd_data` loads the contents of the selected register as held just before that edge if `rd_en` is high, and zero otherwise.
- R5: At each edge, `inh_data` loads the contents of the selected register as held just before that edge if `inh_en` is high, and zero otherwise, independently of `rd_en`.
- R6: An edge with `cyc_start` high while the selected register holds a non-zero value sets `read_err`. The flag stays 1 until `rst`.
- R7: An edge with `cyc_start` high while the selected register is zero leaves `read_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| bank_sel | input | 2 | Storage module select |
| sense | input | 8 | Sense bits to merge into the selected register |
| clr | input | 1 | Clear pulse for the selected register |
| rd_en | input | 1 | Readout enable |
| inh_en | input | 1 | Inhibit output enable |
| cyc_start | input | 1 | Read cycle start strobe that triggers the clear check |
| rd_data | output | 8 | Gated readout of the selected register |
| inh_data | output | 8 | Gated inhibit copy of the selected register |
| read_err | output | 1 | Sticky flag: register not cleared before a read |

## Verification
Each result appears one clock edge after the inputs that cause it:
- `rd_data`, `inh_data` and `read_err` update at the same edge that samples `bank_sel`, the enables and `cyc_start`.
- These outputs use the register contents as they were before that edge.
- Sense bits written at one edge therefore first show on the outputs at the following edge.

The bench drives one cycle per call and samples 1 ns after the rising edge. It compares against expected values computed from the pre-edge state of its own model of the registers, and only then applies that edge's update to the model.

// File: rtl/bank_capture_pkg.sv
package bank_capture_pkg;
  localparam int unsigned DEF_BANKS  = 4;
  localparam int unsigned DEF_CHAR_W = 8;
endpackage

// File: rtl/bank_decode.sv
module bank_decode #(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [SEL_W-1:0]     sel,
  output logic [NUM_BANKS-1:0] hit
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_hit
    assign hit[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/char_latch.sv
module char_latch #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              clr,
  input  logic [CHAR_W-1:0] sense,
  output logic [CHAR_W-1:0] q
);
  // Set-only cell: OR with its own state, clear term has priority.
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (hit) begin
      if (clr) q <= '0;
      else     q <= q | sense;
    end
  end
endmodule

// File: rtl/out_gate.sv
module out_gate #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned CHAR_W    = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_BANKS-1:0]              hit,
  input  logic [NUM_BANKS-1:0][CHAR_W-1:0]  banks,
  input  logic                              rd_en,
  input  logic                              inh_en,
  output logic [CHAR_W-1:0]                 sel_val,
  output logic [CHAR_W-1:0]                 rd_data,
  output logic [CHAR_W-1:0]                 inh_data
);
  // AND-OR select stands in for a wired bus: nothing selected gives zero.
  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (hit[i]) sel_val = sel_val | banks[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      inh_data <= '0;
    end else begin
      rd_data  <= rd_en  ? sel_val : '0;
      inh_data <= inh_en ? sel_val : '0;
    end
  end
endmodule

// File: rtl/reset_check.sv
module reset_check #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic [CHAR_W-1:0] sel_val,
  output logic              err
);
  always_ff @(posedge clk) begin
    if (rst)                          err <= 1'b0;
    else if (cyc_start && |sel_val)   err <= 1'b1;
  end
endmodule

// File: rtl/bank_capture_reg.sv
module bank_capture_reg
  import bank_capture_pkg::*;
#(
  parameter int unsigned NUM_BANKS = DEF_BANKS,
  parameter int unsigned CHAR_W    = DEF_CHAR_W,
  localparam int unsigned SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  bank_sel,
  input  logic [CHAR_W-1:0] sense,
  input  logic              clr,
  input  logic              rd_en,
  input  logic              inh_en,
  input  logic              cyc_start,
  output logic [CHAR_W-1:0] rd_data,
  output logic [CHAR_W-1:0] inh_data,
  output logic              read_err
);
  logic [NUM_BANKS-1:0]             hit;
  logic [NUM_BANKS-1:0][CHAR_W-1:0] banks;
  logic [CHAR_W-1:0]                sel_val;

  bank_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .sel (bank_sel),
    .hit (hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    char_latch #(.CHAR_W(CHAR_W)) u_cell (
      .clk   (clk),
      .rst   (rst),
      .hit   (hit[b]),
      .clr   (clr),
      .sense (sense),
      .q     (banks[b])
    );
  end

  out_gate #(.NUM_BANKS(NUM_BANKS), .CHAR_W(CHAR_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .banks    (banks),
    .rd_en    (rd_en),
    .inh_en   (inh_en),
    .sel_val  (sel_val),
    .rd_data  (rd_data),
    .inh_data (inh_data)
  );

  reset_check #(.CHAR_W(CHAR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cyc_start (cyc_start),
    .sel_val   (sel_val),
    .err       (read_err)
  );
endmodule

// File: rtl/bank_capture_reg_chk.sv
module bank_capture_reg_chk #(
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              inh_en,
  input logic              cyc_start,
  input logic [CHAR_W-1:0] rd_data,
  input logic [CHAR_W-1:0] inh_data,
  input logic              read_err
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && inh_data == '0 && !read_err));

  // R4
  rd_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == '0);

  // R5
  inh_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !inh_en |=> inh_data == '0);

  // R5
  paths_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && inh_en) |=> rd_data == inh_data);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    read_err |=> read_err);

  // R6
  err_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(read_err) |-> $past(cyc_start));
endmodule

bind bank_capture_reg bank_capture_reg_chk #(.CHAR_W(CHAR_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_en     (rd_en),
  .inh_en    (inh_en),
  .cyc_start (cyc_start),
  .rd_data   (rd_data),
  .inh_data  (inh_data),
  .read_err  (read_err)
);

// File: tb/test_bank_capture_reg.sv
`timescale 1ns/1ps
module test_bank_capture_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bank_sel = '0;
  logic [7:0] sense = '0;
  logic       clr = 1'b0, rd_en = 1'b0, inh_en = 1'b0, cyc_start = 1'b0;
  logic [7:0] rd_data, inh_data;
  logic       read_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] mdl [4];
  logic [7:0] exp_rd, exp_inh;
  logic       exp_err;

  always #2.5 clk = ~clk;

  bank_capture_reg i_bank_capture_reg (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .sense(sense), .clr(clr),
    .rd_en(rd_en), .inh_en(inh_en), .cyc_start(cyc_start),
    .rd_data(rd_data), .inh_data(inh_data), .read_err(read_err)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // One clock: drive, take the edge, update the model from pre-edge state.
  task automatic cyc(input logic [1:0] s, input logic [7:0] d, input logic c,
                     input logic r, input logic i, input logic st);
    bank_sel = s; sense = d; clr = c; rd_en = r; inh_en = i; cyc_start = st;
    exp_rd  = r ? mdl[s] : 8'h00;
    exp_inh = i ? mdl[s] : 8'h00;
    if (st && mdl[s] != 8'h00) exp_err = 1'b1;
    @(posedge clk); #1;
    if (c) mdl[s] = 8'h00;
    else   mdl[s] = mdl[s] | d;
    sense = '0; clr = 1'b0; rd_en = 1'b0; inh_en = 1'b0; cyc_start = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 1'b0;
    for (int k = 0; k < 4; k++) mdl[k] = 8'h00;
    exp_err = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    cyc(2'd3, 8'h00, 0, 1, 1, 0);
    chk("R1 rd after reset", rd_data, 8'h00);
    chk("R1 inh after reset", inh_data, 8'h00);
    chk("R1 err after reset", {7'b0, read_err}, 8'h00);
  endtask

  task automatic t_accumulate();
    cyc(2'd1, 8'h05, 0, 0, 0, 0);
    cyc(2'd1, 8'h30, 0, 0, 0, 0);
    cyc(2'd2, 8'h81, 0, 0, 0, 0);
    cyc(2'd1, 8'h00, 0, 1, 0, 0);
    chk("R2 accumulate bank1", rd_data, 8'h35);
    cyc(2'd0, 8'h00, 0, 1, 0, 0);
    chk("R2 bank0 untouched", rd_data, 8'h00);
    cyc(2'd2, 8'h00, 0, 1, 0, 0);
    chk("R2 bank2 own value", rd_data, 8'h81);
  endtask

  task automatic t_gating();
    cyc(2'd1, 8'h00, 0, 1, 0, 0);
    chk("R4 rd enabled", rd_data, 8'h35);
    chk("R5 inh off while rd on", inh_data, 8'h00);
    cyc(2'd1, 8'h00, 0, 0, 1, 0);
    chk("R5 inh enabled", inh_data, 8'h35);
    chk("R4 rd off while inh on", rd_data, 8'h00);
    cyc(2'd2, 8'h00, 0, 1, 1, 0);
    chk("R4 both on rd", rd_data, 8'h81);
    chk("R5 both on inh", inh_data, 8'h81);
  endtask

  task automatic t_clear();
    cyc(2'd1, 8'hFF, 1, 0, 0, 0);
    cyc(2'd1, 8'h00, 0, 1, 0, 0);
    chk("R3 clear wins over sense", rd_data, 8'h00);
    cyc(2'd2, 8'h00, 0, 1, 0, 0);
    chk("R3 other bank kept", rd_data, 8'h81);
  endtask

  task automatic t_check();
    cyc(2'd1, 8'h00, 0, 0, 0, 1);
    chk("R7 strobe on clear bank", {7'b0, read_err}, {7'b0, exp_err});
    chk("R7 err stays 0", {7'b0, read_err}, 8'h00);
    cyc(2'd2, 8'h00, 0, 0, 0, 1);
    chk("R6 strobe on dirty bank", {7'b0, read_err}, 8'h01);
    cyc(2'd2, 8'h00, 1, 0, 0, 0);
    cyc(2'd2, 8'h00, 0, 0, 0, 1);
    chk("R6 err sticky", {7'b0, read_err}, 8'h01);
    do_reset();
    cyc(2'd0, 8'h00, 0, 0, 0, 0);
    chk("R1 err cleared by rst", {7'b0, read_err}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_accumulate();
    t_gating();
    t_clear();
    t_check();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule